// File: doc/BRIEF.md
# Asynchronous SRAM port controller

This block lets a synchronous host read and write an external asynchronous static RAM of 32K bytes. The RAM has 15 address lines, an 8-bit data bus, and active-low select, write strobe and output strobe. The host offers one transfer at a time on a valid/ready request channel: an address, a write flag and write data. The controller turns each transfer into a timed pin sequence. Each pin phase lasts a whole number of clock cycles, and parameters set those counts. Completion is reported as a single-cycle response pulse that carries the read data for reads.

Every transfer runs the same sequence. First there is one setup cycle, in which the new address is driven while all strobes are high. Next comes the access phase, either read or write. Last comes a recovery phase, in which every strobe is high and the data bus is released. When no request is waiting, the controller returns to standby with select high. The output strobe stays high for the whole of every write. The controller drives the data bus only while the write strobe is low. Because of this, the RAM's outputs can never fight the controller's drivers, and the write pulse only has to meet its plain minimum width.

Back-pressure works only on the request side. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. Once taken, its fields are held inside the controller, so the host may change or drop them freely. `req_ready` goes low from acceptance until the last recovery cycle. In that last cycle a new request can be taken with no idle cycle in between. The response channel has no ready input: the host must accept `rsp_valid` in the cycle it appears.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: Outside the access phase of a transfer, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all high and `mem_dq_oe` is low, so the RAM sits in standby.
- R3: A request is accepted on the edge where `req_valid` and `req_ready` are both high. `req_ready` is then low until the last recovery cycle. Changes to `req_addr`, `req_we` and `req_wdata` after acceptance have no effect on the pins or on the response.
- R4: `mem_addr` changes only in cycles where `mem_cs_n` was high in the previous cycle. It takes the accepted address in the setup cycle that directly follows acceptance.
- R5: A read (`req_we`=0) holds `mem_cs_n` and `mem_oe_n` low, with `mem_we_n` high, for READ_CYC cycles starting one cycle after acceptance. `mem_dq_i` is captured on the edge that ends the last of these cycles.
- R6: A write (`req_we`=1) holds `mem_cs_n` and `mem_we_n` low for max(WE_PULSE_CYC, DATA_SETUP_CYC) cycles starting one cycle after acceptance. `mem_oe_n` stays high throughout. `mem_dq_oe` is high exactly while `mem_we_n` is low, with `mem_dq_o` equal to the accepted data.
- R7: `mem_dq_oe` and a low `mem_oe_n` never occur in the same cycle.
- R8: `rsp_valid` is high for exactly one cycle per transfer, in the first cycle after the access phase. For a read, `rsp_rdata` then holds the byte at that address, including bytes written by earlier transfers.
- R9: After each access phase there are TURN_CYC recovery cycles with all strobes high and the bus released. A request waiting in the last recovery cycle is accepted at once, without passing through standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a transfer |
| req_ready | output | 1 | Controller can take a transfer this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` for reads |
| mem_addr | output | 15 | RAM address lines |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | 8 | Data returned from the RAM |

## Verification
The embedded properties assume that every timing count parameter is at least 1. They also assume that reset is held for at least one edge before any request is offered. They place no constraint on how the host presents or withdraws requests, because the fields are latched at acceptance. The stimulus keeps requests idle until reset is released. It then changes request fields at random while a transfer is in flight, and mixes zero-gap back-to-back requests with random idle gaps. The RAM model returns a garbage value until the output strobe has been low for the full read count, so a capture taken too early shows up as a data mismatch.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RECOV = 3'd4
  } asram_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int READ_CYC = 2,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_we,
  output logic      req_ready,
  output logic      accept,
  output asram_st_e state_q,
  output asram_st_e state_d,
  output logic      acc_last,
  output logic      rd_last
);

  localparam int CMAX = imax(imax(READ_CYC, WR_CYC), TURN_CYC);
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          op_we_q;

  assign req_ready = (state_q == ST_IDLE) ||
                     ((state_q == ST_RECOV) && (cnt_q == '0));
  assign accept    = req_valid && req_ready;
  assign acc_last  = ((state_q == ST_READ) || (state_q == ST_WRITE)) && (cnt_q == '0);
  assign rd_last   = (state_q == ST_READ) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_SETUP;
      ST_SETUP: begin
        if (op_we_q) begin
          state_d = ST_WRITE;
          cnt_d   = CW'(WR_CYC - 1);
        end else begin
          state_d = ST_READ;
          cnt_d   = CW'(READ_CYC - 1);
        end
      end
      ST_READ, ST_WRITE: begin
        if (cnt_q == '0) begin
          state_d = ST_RECOV;
          cnt_d   = CW'(TURN_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == '0) state_d = req_valid ? ST_SETUP : ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_we_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) op_we_q <= req_we;
    end
  end

  AST_SETUP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> $past(req_valid && req_ready)); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SETUP) || (state_q == ST_READ) || (state_q == ST_WRITE)) |-> !req_ready); // R3

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int WR_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  asram_st_e         state_d,
  input  logic              acc_last,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LW = $clog2(WR_CYC + 2);

  logic          nxt_rd, nxt_wr;
  logic [LW-1:0] we_low_cnt;

  assign nxt_rd = (state_d == ST_READ);
  assign nxt_wr = (state_d == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      mem_cs_n  <= !(nxt_rd || nxt_wr);
      mem_we_n  <= !nxt_wr;
      mem_oe_n  <= !nxt_rd;
      mem_dq_oe <= nxt_wr;
      rsp_valid <= acc_last;
      if (rd_last) rsp_rdata <= mem_dq_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          we_low_cnt <= '0;
    else if (!mem_we_n)  we_low_cnt <= we_low_cnt + 1'b1;
    else                 we_low_cnt <= '0;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R7

  AST_ADDR_STABLE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R4

  AST_DRIVE_ONLY_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n)); // R6

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == LW'(WR_CYC))); // R6

  AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int READ_CYC       = 2,
  parameter int WE_PULSE_CYC   = 2,
  parameter int DATA_SETUP_CYC = 1,
  parameter int TURN_CYC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int WR_CYC = imax(WE_PULSE_CYC, DATA_SETUP_CYC);

  asram_st_e state_q, state_d;
  logic      accept, acc_last, rd_last;

  asram_fsm #(
    .READ_CYC (READ_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_ready (req_ready),
    .accept    (accept),
    .state_q   (state_q),
    .state_d   (state_d),
    .acc_last  (acc_last),
    .rd_last   (rd_last)
  );

  asram_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WR_CYC (WR_CYC)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state_d   (state_d),
    .acc_last  (acc_last),
    .rd_last   (rd_last),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2

  AST_RECOVERY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV) |-> (mem_cs_n && !mem_dq_oe)); // R9

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int RD = 2;
  localparam int WP = 2;
  localparam int DS = 1;
  localparam int TC = 1;
  localparam int WN = (WP > DS) ? WP : DS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o;
  logic [DW-1:0] mem_dq_i = 8'hEE;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .READ_CYC(RD), .WE_PULSE_CYC(WP),
    .DATA_SETUP_CYC(DS), .TURN_CYC(TC)
  ) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // RAM contents seen by the model, and the host-side shadow
  logic [DW-1:0] ram   [int];
  logic [DW-1:0] shadow[int];

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a) ^ 8'h5A;
  endfunction

  // reference state
  int            acc = -1000;
  int            acc_n = 1;
  bit            acc_we = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] exp_rd = '0;
  bit            p_cs = 1, p_we = 1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dout = '0;
  int            rd_age = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit in_acc, exp_ready, exp_rsp;
      in_acc    = (cyc >= acc + 1) && (cyc <= acc + acc_n);
      exp_ready = !((cyc >= acc) && (cyc <= acc + acc_n + TC - 1));
      exp_rsp   = (cyc == acc + 1 + acc_n);
      // cycle-by-cycle comparison against the reference
      chk(req_ready == exp_ready, "R3 req_ready", req_ready, exp_ready);
      chk(rsp_valid == exp_rsp, "R8 rsp_valid", rsp_valid, exp_rsp);
      if (exp_rsp && !acc_we) chk(rsp_rdata == exp_rd, "R8 rsp_rdata", rsp_rdata, exp_rd);
      chk(mem_cs_n == !in_acc, "R2 R9 mem_cs_n", mem_cs_n, !in_acc);
      chk(mem_oe_n == !(in_acc && !acc_we), "R5 mem_oe_n", mem_oe_n, !(in_acc && !acc_we));
      chk(mem_we_n == !(in_acc && acc_we), "R6 mem_we_n", mem_we_n, !(in_acc && acc_we));
      chk(mem_dq_oe == (in_acc && acc_we), "R6 mem_dq_oe", mem_dq_oe, (in_acc && acc_we));
      if (in_acc) chk(mem_addr == acc_addr, "R3 R4 mem_addr", mem_addr, acc_addr);
      if (mem_dq_oe) chk(mem_dq_o == acc_wdata, "R3 R6 mem_dq_o", mem_dq_o, acc_wdata);
      // RAM model protocol checks
      chk(!(mem_dq_oe && !mem_oe_n), "R7 contention", {mem_dq_oe, mem_oe_n}, 1);
      if (mem_addr != p_addr)
        chk(p_cs, "R4 addr change while selected", p_cs, 1);
      if (!p_cs && !p_we && (mem_cs_n || mem_we_n)) ram[int'(p_addr)] = p_dout;
      // acceptance for the next transfer
      if (req_valid && req_ready) begin
        acc       = cyc + 1;
        acc_we    = req_we;
        acc_n     = req_we ? WN : RD;
        acc_addr  = req_addr;
        acc_wdata = req_wdata;
        if (req_we) shadow[int'(req_addr)] = req_wdata;
        else exp_rd = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : init_val(int'(req_addr));
      end
      // read data path with access delay
      if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age++;
      else rd_age = 0;
      if (rd_age >= RD)
        mem_dq_i <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_val(int'(mem_addr));
      else
        mem_dq_i <= 8'hEE;
      p_cs   = mem_cs_n;
      p_we   = mem_we_n;
      p_addr = mem_addr;
      p_dout = mem_dq_o;
    end
  end

  task automatic do_op(input bit we, input int addr, input int data, input int gap);
    repeat (gap) @(posedge clk);
    #1;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = AW'(addr);
    req_wdata = DW'(data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_we    = 1'($urandom);
    req_addr  = AW'($urandom);
    req_wdata = DW'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe, "R1 mem_dq_oe", mem_dq_oe, 0);
    chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
    chk(req_ready, "R1 req_ready", req_ready, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // directed: boundary addresses, read of unwritten cell, read after write
    do_op(1, 0, 8'hA5, 1);
    do_op(1, 32767, 8'h3C, 2);
    do_op(0, 0, 0, 3);
    do_op(0, 32767, 0, 0);
    do_op(0, 1234, 0, 0);
    // back-to-back writes then reads (R9)
    do_op(1, 5, 8'h11, 0);
    do_op(1, 6, 8'h22, 0);
    do_op(0, 5, 0, 0);
    do_op(0, 6, 0, 0);
    // overwrite and read back
    do_op(1, 5, 8'hFF, 0);
    do_op(0, 5, 0, 4);
    // random mix, small address window for read-after-write hits
    for (int i = 0; i < 400; i++) begin
      int a;
      a = ($urandom % 8 == 0) ? int'($urandom % 32768) : int'($urandom % 32);
      do_op(1'($urandom), a, int'($urandom % 256), int'($urandom % 4));
    end
    repeat (10) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

endmodule